// File: doc/BRIEF.md
# Answer-to-Reset Response Generator

This block belongs to a two-wire serial memory slave. When the host pulses the slave's reset pin high, the block answers with a fixed 32-bit identification word on the serial data line. The word is a build-time parameter that stands in for a value set when the chip is made. No serial command can change it.

The first bit appears once the reset pin falls again. After that, each falling edge of the serial clock presents the next bit, least significant bit first. A falling edge that comes after the last bit releases the data line and the block returns to standby. The block ignores the reset pulse while a nonvolatile write is in progress or while power is not good. If power drops while the response is armed or being sent, the block stops at once and goes back to standby.

All pin inputs are asynchronous to the block clock, so they pass through synchronizers before use. The data line is driven through a separate output enable, which the pad ring combines into a three-state buffer.

Top module: `atr_gen`

## Requirements
- R1: While `rst_n` is low, and on the clock after it goes low, `sda_oe`, `done_pulse` and `abort_pulse` are 0. This holds even in the middle of a response.
- R2: Start condition: power is good, no write is in progress, and `rst_pin` rises and then falls. After the fall, `sda_oe` becomes 1 and `sda_o` carries bit 0 of `ATR_WORD`.
- R3: Each later falling edge of `ser_clk` presents the next bit of `ATR_WORD`, least significant bit first. The n-th falling edge after the response starts shows bit n, for n = 1 to 31.
- R4: The 32nd falling edge of `ser_clk` sets `sda_oe` to 0 and raises `done_pulse` for exactly one clock. `abort_pulse` stays 0.
- R5: A reset-pin pulse whose rising edge arrives while `wr_busy` is 1 is ignored. `sda_oe` stays 0, and later serial clock edges produce no `done_pulse`.
- R6: If `pwr_good` falls while the response is armed or being sent, `sda_oe` goes to 0 within four clocks, and one `abort_pulse` and no `done_pulse` are produced.
- R7: A reset-pin pulse whose rising edge arrives while `pwr_good` is 0 is ignored, and `sda_oe` stays 0.
- R8: Serial clock edges with no reset-pin pulse before them leave `sda_oe` at 0.
- R9: While `sda_oe` is 1, `sda_o` changes only on the clock that follows a detected falling edge of `ser_clk`.
- R10: A response that follows an aborted one and a completed one carries the same 32-bit word, bit for bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_pin | input | 1 | Reset pin from the host (asynchronous) |
| ser_clk | input | 1 | Serial clock pin (asynchronous) |
| wr_busy | input | 1 | High while a nonvolatile write cycle runs |
| pwr_good | input | 1 | High while supply is within range |
| sda_o | output | 1 | Serial data value toward the pad |
| sda_oe | output | 1 | Pad output enable; 0 means high-impedance |
| done_pulse | output | 1 | One-clock pulse when all 32 bits have been sent |
| abort_pulse | output | 1 | One-clock pulse when a response is abandoned on power loss |

## Verification
Three cases are hard to reach from the ports: a power drop in the armed window, one just before the last bit, and one after only a few bits. The bench builds each one from a table entry. Each entry gives the serial-clock fall at which `pwr_good` is pulled low instead of clocking another bit; index 0 means the drop happens while the reset pin is still high. Every pin edge is held for many clocks so that the synchronizers settle, and the bench samples only after that.

// File: rtl/atr_pkg.sv
// Package: shared state encoding and pin indices for the answer-to-reset block.
// Assumes: pin vector order below is used by every module that sees the pins.
package atr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2
    } atr_state_t;

    localparam int unsigned PIN_RST  = 0;
    localparam int unsigned PIN_SCL  = 1;
    localparam int unsigned PIN_BUSY = 2;
    localparam int unsigned PIN_PWR  = 3;
    localparam int unsigned PIN_NUM  = 4;
    localparam int unsigned EDGE_NUM = 2;   // pins whose edges matter: RST, SCL

endpackage

// File: rtl/atr_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pins.
// Also keeps a one-clock-delayed copy of the lowest EDGE_N synchronized pins
// so that the parent can detect their edges.
// Assumes: STAGES >= 2; EDGE_N <= N; all pins reset to 0.
module atr_sync #(
    parameter int unsigned N      = 4,
    parameter int unsigned STAGES = 2,
    parameter int unsigned EDGE_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      pins_async,
    output logic [N-1:0]      lvl,
    output logic [EDGE_N-1:0] lvl_q
);

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [STAGES-1:0] chain;

        // Shift the raw pin through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], pins_async[g]};
        end

        assign lvl[g] = chain[STAGES-1];
    end

    // Delay the edge-relevant levels by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl[EDGE_N-1:0];
    end

endmodule

// File: rtl/atr_shifter.sv
// Module: holds the build-time identification word and presents it LSB first.
// Assumes: load and shift are never high in the same clock.
module atr_shifter #(
    parameter int unsigned WIDTH = 32,
    parameter logic [WIDTH-1:0] WORD = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic shift,
    output logic bit_o
);

    logic [WIDTH-1:0] sh_q;

    // Load the fixed word or move the next bit into position 0.
    always_ff @(posedge clk) begin
        if (!rst_n)      sh_q <= '0;
        else if (load)   sh_q <= WORD;
        else if (shift)  sh_q <= {1'b0, sh_q[WIDTH-1:1]};
    end

    assign bit_o = sh_q[0];

endmodule

// File: rtl/atr_ctrl.sv
// Module: sequencer for the response. It arms on a reset-pin rise, starts on
// the fall, counts serial-clock falls, and ends with done or abort.
// Assumes: edge strobes are one clock wide and come from synchronized pins.
module atr_ctrl
    import atr_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_rise,
    input  logic rst_fall,
    input  logic scl_fall,
    input  logic busy,
    input  logic pwr_ok,
    output logic load,
    output logic shift,
    output logic oe,
    output logic done,
    output logic abort
);

    localparam int unsigned CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    atr_state_t st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic oe_d, done_d, abort_d;

    // Next-state and strobe decode.
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        oe_d    = oe;
        done_d  = 1'b0;
        abort_d = 1'b0;
        load    = 1'b0;
        shift   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (rst_rise && !busy && pwr_ok) st_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!pwr_ok) begin
                    st_d    = ST_IDLE;
                    abort_d = 1'b1;
                end else if (rst_fall) begin
                    st_d  = ST_SEND;
                    load  = 1'b1;
                    oe_d  = 1'b1;
                    cnt_d = '0;
                end
            end
            ST_SEND: begin
                if (!pwr_ok) begin
                    st_d    = ST_IDLE;
                    oe_d    = 1'b0;
                    abort_d = 1'b1;
                end else if (scl_fall) begin
                    if (cnt_q == LAST) begin
                        st_d   = ST_IDLE;
                        oe_d   = 1'b0;
                        done_d = 1'b1;
                    end else begin
                        shift = 1'b1;
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                st_d = ST_IDLE;
                oe_d = 1'b0;
            end
        endcase
    end

    // Register state, bit counter, output enable and completion strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            oe    <= 1'b0;
            done  <= 1'b0;
            abort <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            oe    <= oe_d;
            done  <= done_d;
            abort <= abort_d;
        end
    end

endmodule

// File: rtl/atr_gen.sv
// Module: top of the answer-to-reset generator. It synchronizes the pins,
// finds the reset-pin and serial-clock edges, and drives the data pad value
// and enable.
// Assumes: pins are slow compared with clk (each level held >= 4 clocks).
module atr_gen
    import atr_pkg::*;
#(
    parameter int unsigned WIDTH       = 32,
    parameter logic [WIDTH-1:0] ATR_WORD = 32'h8D1E_5A27,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_pin,
    input  logic ser_clk,
    input  logic wr_busy,
    input  logic pwr_good,
    output logic sda_o,
    output logic sda_oe,
    output logic done_pulse,
    output logic abort_pulse
);

    logic [PIN_NUM-1:0]  pins_raw;
    logic [PIN_NUM-1:0]  pins_lvl;
    logic [EDGE_NUM-1:0] pins_lvl_q;
    logic rst_rise, rst_fall, scl_fall, pwr_ok, busy_lvl;
    logic ld, sh;

    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_RST]  = rst_pin;
        pins_raw[PIN_SCL]  = ser_clk;
        pins_raw[PIN_BUSY] = wr_busy;
        pins_raw[PIN_PWR]  = pwr_good;
    end

    atr_sync #(
        .N      (PIN_NUM),
        .STAGES (SYNC_STAGES),
        .EDGE_N (EDGE_NUM)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_async (pins_raw),
        .lvl        (pins_lvl),
        .lvl_q      (pins_lvl_q)
    );

    assign rst_rise = pins_lvl[PIN_RST] & ~pins_lvl_q[PIN_RST];
    assign rst_fall = ~pins_lvl[PIN_RST] & pins_lvl_q[PIN_RST];
    assign scl_fall = ~pins_lvl[PIN_SCL] & pins_lvl_q[PIN_SCL];
    assign busy_lvl = pins_lvl[PIN_BUSY];
    assign pwr_ok   = pins_lvl[PIN_PWR];

    atr_ctrl #(
        .WIDTH (WIDTH)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_rise (rst_rise),
        .rst_fall (rst_fall),
        .scl_fall (scl_fall),
        .busy     (busy_lvl),
        .pwr_ok   (pwr_ok),
        .load     (ld),
        .shift    (sh),
        .oe       (sda_oe),
        .done     (done_pulse),
        .abort    (abort_pulse)
    );

    atr_shifter #(
        .WIDTH (WIDTH),
        .WORD  (ATR_WORD)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ld),
        .shift (sh),
        .bit_o (sda_o)
    );

endmodule

// File: rtl/atr_gen_chk.sv
// Module: protocol checker for atr_gen, attached by bind below.
// Assumes: pwr_lvl and scl_fall are the synchronized views used by the block.
module atr_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_o,
    input logic sda_oe,
    input logic done_pulse,
    input logic abort_pulse,
    input logic pwr_lvl,
    input logic scl_fall
);

    AST_DONE_ENDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (!sda_oe && $past(sda_oe)));                 // R4
    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);                                // R4
    AST_DONE_ABORT_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_pulse && abort_pulse));                              // R6
    AST_POWER_DROP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && !pwr_lvl) |=> !sda_oe);                          // R6
    AST_ABORT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> !sda_oe);                                   // R6
    AST_START_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(pwr_lvl));                          // R7
    AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && $past(sda_oe) && !$past(scl_fall)) |-> $stable(sda_o)); // R9

endmodule

bind atr_gen atr_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_o       (sda_o),
    .sda_oe      (sda_oe),
    .done_pulse  (done_pulse),
    .abort_pulse (abort_pulse),
    .pwr_lvl     (pwr_ok),
    .scl_fall    (scl_fall)
);

// File: tb/atr_gen_test.sv
// Bench for atr_gen: table-driven response scenarios, then directed cases.
module atr_gen_test;

    localparam logic [31:0] W    = 32'h8D1E_5A27;
    localparam int          HALF = 8;
    localparam int          NCASE = 6;
    // Entry: {busy during pulse, power-drop index (63 = none)}
    localparam logic [6:0] CASES [NCASE] = '{
        {1'b0, 6'd63},
        {1'b1, 6'd63},
        {1'b0, 6'd5},
        {1'b0, 6'd0},
        {1'b0, 6'd31},
        {1'b0, 6'd63}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_pin = 1'b0, ser_clk = 1'b0, wr_busy = 1'b0, pwr_good = 1'b1;
    logic sda_o, sda_oe, done_pulse, abort_pulse;

    int n_chk = 0, n_err = 0, n_done = 0, n_abort = 0;
    logic [31:0] got_word;

    always #10 clk = ~clk;

    atr_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_pin     (rst_pin),
        .ser_clk     (ser_clk),
        .wr_busy     (wr_busy),
        .pwr_good    (pwr_good),
        .sda_o       (sda_o),
        .sda_oe      (sda_oe),
        .done_pulse  (done_pulse),
        .abort_pulse (abort_pulse)
    );

    // Count completion strobes away from the active edge.
    always @(negedge clk) begin
        if (done_pulse)  n_done++;
        if (abort_pulse) n_abort++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic scl_pulse();
        ser_clk = 1'b1; tick(HALF);
        ser_clk = 1'b0; tick(HALF);
    endtask

    task automatic run_case(input logic busy, input int drop);
        int d0, a0;
        logic stopped;
        d0 = n_done; a0 = n_abort; stopped = 1'b0; got_word = '0;
        wr_busy = busy; tick(4);
        rst_pin = 1'b1; tick(HALF);
        if (drop == 0) begin
            pwr_good = 1'b0; tick(HALF);
            rst_pin = 1'b0; tick(HALF);
            chk(sda_oe == 1'b0, "R6 armed drop oe", sda_oe, 0);
            chk(n_abort == a0 + 1, "R6 armed drop abort", n_abort - a0, 1);
            pwr_good = 1'b1; tick(HALF);
            return;
        end
        rst_pin = 1'b0; tick(HALF);
        wr_busy = 1'b0;
        if (busy) begin
            chk(sda_oe == 1'b0, "R5 busy oe", sda_oe, 0);
            for (int k = 0; k < 33; k++) scl_pulse();
            chk(sda_oe == 1'b0 && n_done == d0, "R5 busy no done", n_done - d0, 0);
            return;
        end
        chk(sda_oe == 1'b1, "R2 oe on", sda_oe, 1);
        chk(sda_o == W[0], "R2 bit0", sda_o, W[0]);
        got_word[0] = sda_o;
        for (int i = 1; i < 32; i++) begin
            if (!stopped) begin
                if (i == drop) begin
                    pwr_good = 1'b0; tick(4);
                    chk(sda_oe == 1'b0, "R6 send drop oe", sda_oe, 0);
                    tick(HALF);
                    chk(n_abort == a0 + 1 && n_done == d0, "R6 send drop abort",
                        n_abort - a0, 1);
                    pwr_good = 1'b1; tick(HALF);
                    stopped = 1'b1;
                end else begin
                    scl_pulse();
                    chk(sda_oe == 1'b1, "R3 oe held", sda_oe, 1);
                    chk(sda_o == W[i], $sformatf("R3 bit%0d", i), sda_o, W[i]);
                    got_word[i] = sda_o;
                end
            end
        end
        if (!stopped) begin
            scl_pulse();
            chk(sda_oe == 1'b0, "R4 oe released", sda_oe, 0);
            chk(n_done == d0 + 1, "R4 one done", n_done - d0, 1);
            chk(n_abort == a0, "R4 no abort", n_abort - a0, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        tick(3);
        chk(sda_oe == 1'b0 && done_pulse == 1'b0 && abort_pulse == 1'b0,
            "R1 reset state", sda_oe, 0);
        rst_n = 1'b1; tick(4);

        for (int c = 0; c < NCASE; c++) begin
            run_case(CASES[c][6], int'(CASES[c][5:0]));
        end
        chk(got_word == W, "R10 word repeats", got_word, W);

        // R8: serial clock alone does nothing.
        for (int k = 0; k < 4; k++) begin
            scl_pulse();
            chk(sda_oe == 1'b0, "R8 no pulse oe", sda_oe, 0);
        end

        // R7: pulse while power is low is ignored.
        pwr_good = 1'b0; tick(HALF);
        rst_pin = 1'b1; tick(HALF);
        pwr_good = 1'b1; tick(HALF);
        rst_pin = 1'b0; tick(HALF);
        chk(sda_oe == 1'b0, "R7 low power oe", sda_oe, 0);

        // R1: block reset in the middle of a response.
        rst_pin = 1'b1; tick(HALF);
        rst_pin = 1'b0; tick(HALF);
        scl_pulse();
        chk(sda_oe == 1'b1, "R1 mid-send active", sda_oe, 1);
        rst_n = 1'b0; tick(2);
        chk(sda_oe == 1'b0 && done_pulse == 1'b0 && abort_pulse == 1'b0,
            "R1 mid-send reset", sda_oe, 0);
        rst_n = 1'b1; tick(4);
        scl_pulse();
        chk(sda_oe == 1'b0, "R1 stays idle", sda_oe, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule